// File: doc/BRIEF.md
# Wake-Out Strobe Pulse Generator

This block stretches a polling event into a wake-out strobe of programmable length. Each period trigger starts a pulse on a down counter. The counter steps once for every polling-clock tick, so the pulse lasts a programmed number of polling-clock periods, not core clock cycles. A zero in the delay field selects the longest pulse, 32 ticks.

One write-only configuration register holds the delay, an enable, an output gate and a source select. The source select can replace the internal pulse on the output with an external strobe. A write reaches the counter in the same clock edge that stores it. Rewriting the delay while a pulse is running therefore restarts that pulse with the new length.

Top module: `wake_pulse_gen`

## Requirements
- R1: After a synchronous active-low reset, every configuration bit is 0, `cfg_rdata` reads 0 and `strobe_out` is low.
- R2: The configuration word is laid out as delay in bits [4:0], source select in bit 5, output gate in bit 6 and enable in bit 7. `cfg_rdata` returns the last word written.
- R3: With enable set, a delay D from 1 to 31 keeps the internal pulse high for exactly D clock edges at which `tick_en` is high, counted from the load.
- R4: A delay of 0 gives a pulse of 32 ticks.
- R5: A write with bit 7 set loads the counter from the written delay at that same edge. A running pulse restarts with the new length.
- R6: A `period_trig` pulse while enabled reloads the counter from the stored delay and raises the internal pulse in the next cycle. A write in the same cycle takes priority.
- R7: The counter changes only on edges where `tick_en` is high. While `tick_en` is low, a running pulse stays high.
- R8: A write with bit 7 clear empties the counter at that edge, so `strobe_out` is low in the next cycle. While enable is clear, `period_trig` has no effect.
- R9: While bit 6 is clear, `strobe_out` is low whatever the pulse state.
- R10: While bits 5 and 6 are both set, `strobe_out` follows `alt_strobe_in` combinationally, and the internal pulse is not shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Polling-clock enable, one cycle per tick |
| period_trig | input | 1 | Polling-period event that starts a pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration readback |
| alt_strobe_in | input | 1 | External strobe, selectable as the output source |
| strobe_out | output | 1 | Wake-out strobe |

## Verification
The bench builds the block with its default 5-bit delay field. With that setting, all 32 delay codes can be swept, including the zero code that wraps to the maximum. The sweep runs twice: once with a tick on every cycle and once with a tick on every third cycle. The second pass shows that the pulse width is counted in ticks and not in clock cycles. Directed cases cover a restart on write, a stall while ticks are absent, disabling mid-pulse, the output gate and the external source.

// File: rtl/wkp_pkg.sv
// Package: shared settings and types for the wake-out pulse generator.
// Assumes: nothing; it holds only declarations.
package wkp_pkg;
    parameter int DEFAULT_DLY_W = 5;

    // Which source drives the strobe output.
    typedef enum logic {
        SRC_PULSE = 1'b0,
        SRC_EXT   = 1'b1
    } strobe_src_e;
endpackage

// File: rtl/wkp_cfg_reg.sv
// Module: configuration register of the pulse generator.
// Assumes: the write data is valid whenever we is high; the value resets to zero.
module wkp_cfg_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Store each written word; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wdata;
    end
endmodule

// File: rtl/wkp_down_counter.sv
// Module: loadable down counter that times the wake-out pulse.
// Assumes: load_val lies in 1..2**(CNT_W-1); run_en low empties the counter.
module wkp_down_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt_q,
    output logic             active
);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(1) << (CNT_W - 1);

    // Priority: disable, then load, then a tick-qualified decrement.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en)          cnt_q <= '0;
        else if (load)                  cnt_q <= load_val;
        else if (tick && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    // The pulse is high while any count remains.
    always_comb active = (cnt_q != '0);

    p_disable_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (cnt_q == '0));
    p_load_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && load) |=> (cnt_q == $past(load_val)));
    p_tick_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !load && tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
    p_stall_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !load && !tick) |=> $stable(cnt_q));
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= MAX_CNT);
endmodule

// File: rtl/wkp_out_sel.sv
// Module: output source select and output gate.
// Assumes: both sources are single-bit levels; the path is purely combinational.
module wkp_out_sel
    import wkp_pkg::*;
(
    input  logic        gate_en,
    input  strobe_src_e src,
    input  logic        pulse_in,
    input  logic        ext_in,
    output logic        strobe
);
    // Pick the source, then gate it onto the pin.
    always_comb begin
        strobe = 1'b0;
        if (gate_en) strobe = (src == SRC_EXT) ? ext_in : pulse_in;
    end
endmodule

// File: rtl/wake_pulse_gen.sv
// Module: wake-out strobe pulse generator (top).
// Assumes: tick_en marks polling-clock ticks in the core clock domain, and
// all inputs are synchronous to clk.
module wake_pulse_gen
    import wkp_pkg::*;
#(
    parameter int DLY_W = DEFAULT_DLY_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic               period_trig,
    input  logic               cfg_we,
    input  logic [DLY_W+2:0]   cfg_wdata,
    output logic [DLY_W+2:0]   cfg_rdata,
    input  logic               alt_strobe_in,
    output logic               strobe_out
);
    localparam int CFG_W   = DLY_W + 3;
    localparam int CNT_W   = DLY_W + 1;
    localparam int SRC_BIT = DLY_W;
    localparam int OE_BIT  = DLY_W + 1;
    localparam int EN_BIT  = DLY_W + 2;
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(1) << DLY_W;

    logic [CFG_W-1:0] cfg_q;
    logic [DLY_W-1:0] dly_sel;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] cnt_q;
    logic             run_en, load, pulse;
    strobe_src_e      src;

    wkp_cfg_reg #(.W(CFG_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .q(cfg_q)
    );

    // Register readback.
    always_comb cfg_rdata = cfg_q;

    // A write takes effect on the counter in the same edge that stores it.
    always_comb begin
        run_en  = cfg_we ? cfg_wdata[EN_BIT] : cfg_q[EN_BIT];
        load    = run_en && (cfg_we || period_trig);
        dly_sel = cfg_we ? cfg_wdata[DLY_W-1:0] : cfg_q[DLY_W-1:0];
    end

    // Map the delay code to a width; code zero means the maximum.
    always_comb load_val = (dly_sel == '0) ? MAX_CNT : {1'b0, dly_sel};

    wkp_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .load(load),
        .load_val(load_val), .tick(tick_en), .cnt_q(cnt_q), .active(pulse)
    );

    // Decode the source select field.
    always_comb src = cfg_q[SRC_BIT] ? SRC_EXT : SRC_PULSE;

    wkp_out_sel u_sel (
        .gate_en(cfg_q[OE_BIT]), .src(src), .pulse_in(pulse),
        .ext_in(alt_strobe_in), .strobe(strobe_out)
    );

    p_gate_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q[OE_BIT] |-> !strobe_out);
    p_ext_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[OE_BIT] && cfg_q[SRC_BIT]) |-> (strobe_out == alt_strobe_in));
    p_write_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[EN_BIT] && cfg_wdata[DLY_W-1:0] != '0)
        |=> (cnt_q == CNT_W'($past(cfg_wdata[DLY_W-1:0]))));
    p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata == $past(cfg_wdata)));
endmodule

// File: tb/wake_pulse_gen_test.sv
module wake_pulse_gen_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       period_trig = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       alt_strobe_in = 1'b0;
    logic       strobe_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wake_pulse_gen uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .period_trig(period_trig),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .alt_strobe_in(alt_strobe_in), .strobe_out(strobe_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [7:0] d);
        cfg_we = 1'b1; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic trig();
        period_trig = 1'b1;
        step();
        period_trig = 1'b0;
    endtask

    // Count tick edges while the strobe is high; one tick every m cycles.
    task automatic measure(input int m, output int n);
        int ph = 0;
        n = 0;
        tick_en = 1'b1;
        for (int g = 0; g < 2000; g++) begin
            if (!strobe_out) break;
            if (tick_en) n++;
            step();
            ph++;
            tick_en = ((ph % m) == 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        int exp;
        repeat (3) step();
        rst_n = 1'b1;
        // R1: reset state
        check(cfg_rdata == 8'h00, "R1", cfg_rdata, 0);
        check(strobe_out == 1'b0, "R1", strobe_out, 0);
        // R8: trigger while disabled has no effect
        trig();
        repeat (2) begin
            check(strobe_out == 1'b0, "R8", strobe_out, 0);
            step();
        end

        // R3/R4 sweep, tick every cycle and every third cycle
        for (int m = 1; m <= 3; m += 2) begin
            for (int d = 0; d < 32; d++) begin
                wr({3'b110, 5'(d)});
                check(cfg_rdata == {3'b110, 5'(d)}, "R2", cfg_rdata, {3'b110, 5'(d)});
                trig();
                check(strobe_out == 1'b1, "R6", strobe_out, 1);
                measure(m, n);
                exp = (d == 0) ? 32 : d;
                check(n == exp, (d == 0) ? "R4" : "R3", n, exp);
            end
        end

        // R7: no ticks, pulse holds
        tick_en = 1'b0;
        wr(8'hC3);
        trig();
        repeat (6) begin
            check(strobe_out == 1'b1, "R7", strobe_out, 1);
            step();
        end
        measure(1, n);
        check(n == 3, "R7", n, 3);

        // R5: rewrite mid-pulse restarts with new width
        wr(8'hCA);
        trig();
        tick_en = 1'b1;
        repeat (3) step();
        wr(8'hC4);
        measure(1, n);
        check(n == 4, "R5", n, 4);

        // R8: disable mid-pulse
        tick_en = 1'b1;
        wr(8'hD4);
        trig();
        step();
        wr(8'h54);
        check(strobe_out == 1'b0, "R8", strobe_out, 0);
        trig();
        repeat (3) begin
            check(strobe_out == 1'b0, "R8", strobe_out, 0);
            step();
        end

        // R9: gate off with a running pulse
        tick_en = 1'b0;
        wr(8'h85);
        trig();
        repeat (3) begin
            check(strobe_out == 1'b0, "R9", strobe_out, 0);
            step();
        end

        // R10: external source
        wr(8'hFF);
        alt_strobe_in = 1'b0; #1;
        check(strobe_out == 1'b0, "R10", strobe_out, 0);
        alt_strobe_in = 1'b1; #1;
        check(strobe_out == 1'b1, "R10", strobe_out, 1);
        wr(8'h60);
        alt_strobe_in = 1'b0; #1;
        check(strobe_out == 1'b0, "R10", strobe_out, 0);
        alt_strobe_in = 1'b1; #1;
        check(strobe_out == 1'b1, "R10", strobe_out, 1);
        wr(8'h20);
        check(strobe_out == 1'b0, "R9", strobe_out, 0);
        alt_strobe_in = 1'b0;

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule